// File: doc/BRIEF.md
# Count/Compare Timer Interrupt Unit

This block holds a free-running count register and a compare register of the same width, 32 bits by default. The count advances by one on each tick-enable pulse. When the count reaches the compare value, the block raises a timer interrupt. Software can overwrite either register through its own write port. A write to the compare register doubles as the acknowledge: it clears the pending flag and drops the interrupt.

A hold input freezes the count and blocks any new interrupt while it is set. The interrupt is steered onto one of eight output lines by a 3-bit select input. A build parameter chooses the revision mode. In revision-2 mode the block also presents a pending flag; in the other mode that flag always reads 0, and the interrupt line behaves the same way in both modes.

Top module: `cmp_timer`

## Requirements
- R1: After reset the count reads 1, the compare reads 0, the pending flag is 0 and every interrupt line is 0.
- R2: A tick pulse with hold clear and no count write raises the count by exactly one on that clock edge. With no tick, the count keeps its value.
- R3: While hold is set, tick pulses leave the count unchanged.
- R4: A count write loads the written value on that edge. When a tick arrives in the same cycle, the written value is loaded and the tick is dropped.
- R5: On the edge where the count is updated to a value equal to the compare value, the interrupt is raised. It stays raised while the count keeps advancing past the match.
- R6: A compare write loads the new compare value and clears the interrupt on that edge. If a match happens in the same cycle, the write wins and the interrupt stays clear.
- R7: While the interrupt is raised, exactly one line is asserted: bit k of the 8-bit line vector, where k is the 3-bit select value. A change of the select moves the asserted line to the new position without waiting for a clock edge.
- R8: While hold is set, no new interrupt is raised, even when a count write loads the compare value.
- R9: In revision-2 mode the pending flag equals the interrupt state. In the other mode the pending flag is always 0, and the line vector behaves exactly as in revision-2 mode.
- R10: The count wraps from all ones to 0 on a tick. A wrap onto a compare value of 0 raises the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count advance pulse |
| hold | input | 1 | Freeze count and block new interrupts |
| cnt_wr | input | 1 | Count register write strobe |
| cnt_wdata | input | 32 | Count write value |
| cmp_wr | input | 1 | Compare register write strobe (acknowledge) |
| cmp_wdata | input | 32 | Compare write value |
| line_sel | input | 3 | Interrupt line select |
| count_q | output | 32 | Count read value |
| compare_q | output | 32 | Compare read value |
| pending | output | 1 | Pending timer flag (revision-2 mode only) |
| irq_lines | output | 8 | Interrupt line vector |

## Verification
The bench builds two copies of the block side by side: one with the revision-2 parameter set to 1 and one with it set to 0. Both use the default 32-bit width and 3-bit select, and both see the same stimulus. This shows that both modes drive the same interrupt lines, and that only the revision-2 copy reports a pending flag. Because the width is a full 32 bits, the wrap from all ones to 0 is reached through a count write, not through billions of ticks.

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int CNT_W = 32,
  parameter int SEL_W = 3,
  parameter bit REV2  = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               hold,
  input  logic               cnt_wr,
  input  logic [CNT_W-1:0]   cnt_wdata,
  input  logic               cmp_wr,
  input  logic [CNT_W-1:0]   cmp_wdata,
  input  logic [SEL_W-1:0]   line_sel,
  output logic [CNT_W-1:0]   count_q,
  output logic [CNT_W-1:0]   compare_q,
  output logic               pending,
  output logic [(1<<SEL_W)-1:0] irq_lines
);
  localparam int N_LINES = 1 << SEL_W;

  logic             irq_act;
  logic             advance;
  logic             cnt_upd;
  logic [CNT_W-1:0] cnt_nxt;
  logic             hit;

  assign advance = tick && !hold;
  assign cnt_upd = cnt_wr || advance;
  assign cnt_nxt = cnt_wr ? cnt_wdata : count_q + CNT_W'(1);
  assign hit     = cnt_upd && !hold && (cnt_nxt == compare_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q   <= CNT_W'(1);
      compare_q <= '0;
      irq_act   <= 1'b0;
    end else begin
      if (cnt_upd) count_q <= cnt_nxt;
      if (cmp_wr) begin
        compare_q <= cmp_wdata;
        irq_act   <= 1'b0;
      end else if (hit) begin
        irq_act   <= 1'b1;
      end
    end
  end

  assign pending = REV2 ? irq_act : 1'b0;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    assign irq_lines[i] = irq_act && (line_sel == SEL_W'(i));
  end

  // R7
  one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_lines));

  // R3
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !cnt_wr) |=> $stable(count_q));

  // R2
  tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !hold && !cnt_wr) |=> count_q == $past(count_q) + CNT_W'(1));

  // R4
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> count_q == $past(cnt_wdata));

  // R6
  cmp_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr |=> (irq_lines == '0 && compare_q == $past(cmp_wdata)));

  // R8
  hold_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && irq_lines == '0) |=> irq_lines == '0);

  // R9
  pend_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending == (REV2 && (irq_lines != '0)));
endmodule

// File: tb/sim_cmp_timer.sv
module sim_cmp_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, hold = 1'b0, cnt_wr = 1'b0, cmp_wr = 1'b0;
  logic [31:0] cnt_wdata = '0, cmp_wdata = '0;
  logic [2:0]  line_sel = '0;
  logic [31:0] c0, p0, c1, p1;
  logic        pd0, pd1;
  logic [7:0]  l0, l1;

  int n_chk = 0, n_bad = 0;

  typedef struct {
    logic [31:0] cnt;
    logic [31:0] cmp;
    logic        act;
    logic [2:0]  sel;
    string       tag;
  } exp_t;
  exp_t q[$];
  exp_t e;

  logic [31:0] m_cnt = 32'd1, m_cmp = '0;
  logic        m_act = 1'b0;

  always #2 clk = ~clk;

  cmp_timer #(.REV2(1'b1)) u0 (.clk, .rst_n, .tick, .hold, .cnt_wr, .cnt_wdata,
    .cmp_wr, .cmp_wdata, .line_sel, .count_q(c0), .compare_q(p0), .pending(pd0), .irq_lines(l0));
  cmp_timer #(.REV2(1'b0)) u1 (.clk, .rst_n, .tick, .hold, .cnt_wr, .cnt_wdata,
    .cmp_wr, .cmp_wdata, .line_sel, .count_q(c1), .compare_q(p1), .pending(pd1), .irq_lines(l1));

  function automatic logic [7:0] lines_of(logic a, logic [2:0] s);
    return a ? (8'd1 << s) : 8'd0;
  endfunction

  task automatic check(string tag, logic [31:0] cnt, logic [31:0] cmp, logic act, logic [2:0] s);
    n_chk++;
    if (c0 !== cnt || p0 !== cmp || pd0 !== act || l0 !== lines_of(act, s)) begin
      n_bad++;
      $display("FAIL %s: cnt=%h cmp=%h pend=%b lines=%b expected cnt=%h cmp=%h pend=%b lines=%b",
        tag, c0, p0, pd0, l0, cnt, cmp, act, lines_of(act, s));
    end
    n_chk++;
    if (pd1 !== 1'b0 || l1 !== lines_of(act, s) || c1 !== cnt) begin
      n_bad++;
      $display("FAIL R9 (%s): mode0 pend=%b lines=%b cnt=%h expected pend=0 lines=%b cnt=%h",
        tag, pd1, l1, c1, lines_of(act, s), cnt);
    end
  endtask

  task automatic step(logic t, logic h, logic cw, logic [31:0] cwd,
                      logic pw, logic [31:0] pwd, logic [2:0] s, string tag);
    logic        upd;
    logic [31:0] nxt;
    @(negedge clk);
    tick = t; hold = h; cnt_wr = cw; cnt_wdata = cwd;
    cmp_wr = pw; cmp_wdata = pwd; line_sel = s;
    upd = cw || (t && !h);
    nxt = cw ? cwd : ((t && !h) ? m_cnt + 32'd1 : m_cnt);
    if (pw) m_act = 1'b0;
    else if (upd && !h && nxt == m_cmp) m_act = 1'b1;
    m_cnt = nxt;
    if (pw) m_cmp = pwd;
    e.cnt = m_cnt; e.cmp = m_cmp; e.act = m_act; e.sel = s; e.tag = tag;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      check(x.tag, x.cnt, x.cmp, x.act, x.sel);
    end
  end

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 reset", 32'd1, 32'd0, 1'b0, 3'd0);

    // R2 ticks and idle cycles
    step(1, 0, 0, 0, 0, 0, 0, "R2 tick");
    step(1, 0, 0, 0, 0, 0, 0, "R2 tick");
    step(0, 0, 0, 0, 0, 0, 0, "R2 idle");
    // R3 hold
    step(1, 1, 0, 0, 0, 0, 0, "R3 hold tick");
    step(1, 1, 0, 0, 0, 0, 0, "R3 hold tick");
    // R4 write beats tick
    step(1, 0, 1, 32'd100, 0, 0, 0, "R4 write+tick");
    // R5 match
    step(0, 0, 0, 0, 1, 32'd105, 3'd2, "R6 cmp load");
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, 0, 3'd2, "R5 approach/match");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0, 3'd2, "R5 stays past match");
    // R7 immediate reroute
    @(negedge clk);
    tick = 1'b0; line_sel = 3'd6;
    #0.5;
    n_chk++;
    if (l0 !== 8'b0100_0000) begin
      n_bad++;
      $display("FAIL R7 reroute: lines=%b expected=%b", l0, 8'b0100_0000);
    end
    step(0, 0, 0, 0, 0, 0, 3'd6, "R7 line 6");
    step(0, 0, 0, 0, 0, 0, 3'd7, "R7 line 7");
    // R6 ack
    step(0, 0, 0, 0, 1, 32'd200, 3'd7, "R6 ack");
    step(0, 0, 1, 32'd199, 0, 0, 3'd7, "R4 load 199");
    step(1, 0, 0, 0, 1, 32'd500, 3'd7, "R6 ack beats match");
    step(0, 0, 0, 0, 0, 0, 3'd7, "R6 stays clear");
    // R8 hold blocks
    step(0, 0, 0, 0, 1, 32'd300, 3'd1, "R6 cmp 300");
    step(0, 1, 1, 32'd300, 0, 0, 3'd1, "R8 held write onto compare");
    step(1, 1, 0, 0, 0, 0, 3'd1, "R8 held tick");
    step(1, 0, 0, 0, 0, 0, 3'd1, "R8 release no match");
    // R10 wrap onto zero
    step(0, 0, 0, 0, 1, 32'd0, 3'd0, "R6 cmp 0");
    step(0, 0, 1, 32'hFFFF_FFFF, 0, 0, 3'd0, "R4 load all ones");
    step(1, 0, 0, 0, 0, 0, 3'd0, "R10 wrap match");
    step(1, 0, 0, 0, 0, 0, 3'd5, "R10 after wrap");
    // R5 count write matching
    step(0, 0, 0, 0, 1, 32'd40, 3'd3, "R6 cmp 40");
    step(0, 0, 1, 32'd40, 0, 0, 3'd3, "R5 write match");
    step(0, 0, 0, 0, 0, 0, 3'd3, "R5 hold level");

    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule